// File: doc/BRIEF.md
# Glitch Controller Command Decoder

This block sits between a UART byte receiver, a UART byte transmitter and a glitch pulse sequencer. It reads a stream of received bytes, each marked by a one-cycle valid strobe. Single-byte ASCII opcodes, some followed by argument bytes, are turned into writes to the timing and mode registers or into one-cycle action pulses for the sequencer. The register values are driven continuously on output pins so the sequencer can read them at any time.

Replies are of two kinds. An opcode the decoder does not know is sent back unchanged. The identification opcode produces a fixed five-character string. Reply requests go into a small queue. A serializer drains the queue onto a valid/ready byte output.

The transmit side follows valid/ready rules. Once `tx_valid` is high, `tx_data` holds its value and `tx_valid` stays high until a cycle in which `tx_ready` is also high. Only after that does the next reply byte appear. The receive side cannot be stalled. While the transmitter is held off, the reply queue absorbs up to `REQ_DEPTH` pending requests. A request that arrives while the queue is full is dropped.

Top module: `glitch_cmd_ctrl`

## Requirements
- R1: After reset the registers read as follows: delay 0x0000, pulse width 0x01, pulse count 0x01, spacing 0x0000, reset length 0x0000, reset mode 0 (Pulse). No action pulse and no `tx_valid` is high.
- R2: The 16-bit registers take two argument bytes, high byte first. Opcode 0x64 writes delay, 0x73 writes spacing and 0x72 writes reset length. The new value appears on the output in the cycle after the second argument byte.
- R3: The 8-bit registers take one argument byte. Opcode 0x77 writes pulse width and 0x6E writes pulse count. The new value appears in the cycle after the argument byte.
- R4: Argument bytes are stored as data and never decoded as opcodes, even when their value equals an opcode.
- R5: A register keeps its old value until its last argument byte has arrived. No register or mode output changes in a cycle that does not follow a received byte.
- R6: Each action opcode gives exactly one one-cycle pulse, in the cycle after the opcode byte. 0x74 pulses `start_seq`, 0x61 pulses `arm_toggle` and 0x70 pulses `reset_target`. At most one of these three pulses is high in any cycle.
- R7: The reset-mode opcodes set `reset_mode` without arguments. 0x75 sets 0 (Pulse), 0x69 sets 1 (Arm) and 0x79 sets 2 (None). The value 3 never appears.
- R8: Configuration opcodes and their arguments produce no action pulse and no reply.
- R9: Every byte that is neither a known opcode nor an argument is sent back unchanged on the transmit side, one byte per such input, in order of arrival.
- R10: Opcode 0x68 sends the five bytes 0x46 0x4C 0x54 0x30 0x31 ("FLT01") in that order. Replies from different requests never interleave.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte is available |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| delay_cyc | output | 16 | Delay before the first pulse |
| width_cyc | output | 8 | Pulse width |
| count_cyc | output | 8 | Number of pulses |
| spacing_cyc | output | 16 | Gap between pulses |
| reset_len | output | 16 | Target reset length |
| reset_mode | output | 2 | Action after a target reset: 0 Pulse, 1 Arm, 2 None |
| start_seq | output | 1 | One-cycle request to start a pulse sequence |
| arm_toggle | output | 1 | One-cycle request to toggle the arm state |
| reset_target | output | 1 | One-cycle request to start a target reset |

## Verification
The bench sends argument bytes whose values equal action opcodes. A decoder that lost its argument state would fire a start pulse and leave the width register unchanged. It checks a 16-bit register between its two argument bytes, which exposes a design that writes early or swaps byte order. Replies are sent under an irregular ready pattern and a long stall, so a serializer that skips a character, repeats one, lets data drift while stalled or interleaves two requests breaks the expected byte stream. Every register and action pulse is compared each cycle, so any stray write or pulse during a configuration command is caught.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE = 2'd0,
    MODE_ARM   = 2'd1,
    MODE_NONE  = 2'd2
  } rmode_e;

  typedef enum logic [2:0] {
    TGT_DELAY, TGT_WIDTH, TGT_COUNT, TGT_SPACE, TGT_RLEN
  } tgt_e;

  localparam logic [7:0] OP_DELAY = 8'h64;
  localparam logic [7:0] OP_WIDTH = 8'h77;
  localparam logic [7:0] OP_COUNT = 8'h6E;
  localparam logic [7:0] OP_SPACE = 8'h73;
  localparam logic [7:0] OP_RLEN  = 8'h72;
  localparam logic [7:0] OP_START = 8'h74;
  localparam logic [7:0] OP_ARM   = 8'h61;
  localparam logic [7:0] OP_TRST  = 8'h70;
  localparam logic [7:0] OP_MPULS = 8'h75;
  localparam logic [7:0] OP_MARM  = 8'h69;
  localparam logic [7:0] OP_MNONE = 8'h79;
  localparam logic [7:0] OP_IDENT = 8'h68;

  localparam int ID_LEN = 5;
  localparam int ID_IW  = $clog2(ID_LEN);

  function automatic logic [7:0] id_char(input logic [ID_IW-1:0] i);
    case (i)
      3'd0:    id_char = 8'h46;
      3'd1:    id_char = 8'h4C;
      3'd2:    id_char = 8'h54;
      3'd3:    id_char = 8'h30;
      default: id_char = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/gcc_parser.sv
module gcc_parser
  import gcc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   rx_data,
  input  logic            rx_valid,
  output logic [2*DW-1:0] delay_q,
  output logic [DW-1:0]   width_q,
  output logic [DW-1:0]   count_q,
  output logic [2*DW-1:0] space_q,
  output logic [2*DW-1:0] rlen_q,
  output logic [1:0]      mode_q,
  output logic            start_o,
  output logic            arm_o,
  output logic            trst_o,
  output logic            req_valid,
  output logic            req_id,
  output logic [DW-1:0]   req_byte
);
  logic          in_arg, need_two;
  tgt_e          tgt_q;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q   <= '0;
      width_q   <= DW'(1);
      count_q   <= DW'(1);
      space_q   <= '0;
      rlen_q    <= '0;
      mode_q    <= MODE_PULSE;
      start_o   <= 1'b0;
      arm_o     <= 1'b0;
      trst_o    <= 1'b0;
      req_valid <= 1'b0;
      req_id    <= 1'b0;
      req_byte  <= '0;
      in_arg    <= 1'b0;
      need_two  <= 1'b0;
      tgt_q     <= TGT_DELAY;
      hi_q      <= '0;
    end else begin
      start_o   <= 1'b0;
      arm_o     <= 1'b0;
      trst_o    <= 1'b0;
      req_valid <= 1'b0;
      if (rx_valid) begin
        if (in_arg) begin
          if (need_two) begin
            hi_q     <= rx_data;
            need_two <= 1'b0;
          end else begin
            in_arg <= 1'b0;
            case (tgt_q)
              TGT_DELAY: delay_q <= {hi_q, rx_data};
              TGT_SPACE: space_q <= {hi_q, rx_data};
              TGT_RLEN:  rlen_q  <= {hi_q, rx_data};
              TGT_WIDTH: width_q <= rx_data;
              default:   count_q <= rx_data;
            endcase
          end
        end else begin
          case (rx_data)
            OP_DELAY: begin in_arg <= 1'b1; need_two <= 1'b1; tgt_q <= TGT_DELAY; end
            OP_SPACE: begin in_arg <= 1'b1; need_two <= 1'b1; tgt_q <= TGT_SPACE; end
            OP_RLEN:  begin in_arg <= 1'b1; need_two <= 1'b1; tgt_q <= TGT_RLEN;  end
            OP_WIDTH: begin in_arg <= 1'b1; need_two <= 1'b0; tgt_q <= TGT_WIDTH; end
            OP_COUNT: begin in_arg <= 1'b1; need_two <= 1'b0; tgt_q <= TGT_COUNT; end
            OP_START: start_o <= 1'b1;
            OP_ARM:   arm_o   <= 1'b1;
            OP_TRST:  trst_o  <= 1'b1;
            OP_MPULS: mode_q  <= MODE_PULSE;
            OP_MARM:  mode_q  <= MODE_ARM;
            OP_MNONE: mode_q  <= MODE_NONE;
            OP_IDENT: begin req_valid <= 1'b1; req_id <= 1'b1; req_byte <= rx_data; end
            default:  begin req_valid <= 1'b1; req_id <= 1'b0; req_byte <= rx_data; end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gcc_reply_fifo.sv
module gcc_reply_fifo #(
  parameter int EW    = 9,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          full, do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/gcc_reply_ser.sv
module gcc_reply_ser
  import gcc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  logic          head_id,
  input  logic [DW-1:0] head_byte,
  output logic          pop,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  logic             busy, is_id;
  logic [ID_IW-1:0] idx;

  assign pop      = !busy && !empty;
  assign tx_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_id   <= 1'b0;
      idx     <= '0;
      tx_data <= '0;
    end else if (pop) begin
      busy    <= 1'b1;
      is_id   <= head_id;
      idx     <= '0;
      tx_data <= head_id ? id_char('0) : head_byte;
    end else if (busy && tx_ready) begin
      if (is_id && idx != ID_IW'(ID_LEN - 1)) begin
        idx     <= idx + 1'b1;
        tx_data <= id_char(idx + 1'b1);
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/glitch_cmd_ctrl.sv
module glitch_cmd_ctrl #(
  parameter int DW        = 8,
  parameter int REQ_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   rx_data,
  input  logic            rx_valid,
  output logic [DW-1:0]   tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [2*DW-1:0] delay_cyc,
  output logic [DW-1:0]   width_cyc,
  output logic [DW-1:0]   count_cyc,
  output logic [2*DW-1:0] spacing_cyc,
  output logic [2*DW-1:0] reset_len,
  output logic [1:0]      reset_mode,
  output logic            start_seq,
  output logic            arm_toggle,
  output logic            reset_target
);
  localparam int EW = DW + 1;

  logic          req_valid, req_id, pop, empty;
  logic [DW-1:0] req_byte;
  logic [EW-1:0] head;

  gcc_parser #(.DW(DW)) u_parse (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .delay_q(delay_cyc), .width_q(width_cyc), .count_q(count_cyc),
    .space_q(spacing_cyc), .rlen_q(reset_len), .mode_q(reset_mode),
    .start_o(start_seq), .arm_o(arm_toggle), .trst_o(reset_target),
    .req_valid(req_valid), .req_id(req_id), .req_byte(req_byte)
  );

  gcc_reply_fifo #(.EW(EW), .DEPTH(REQ_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(req_valid), .din({req_id, req_byte}),
    .pop(pop), .head(head), .empty(empty)
  );

  gcc_reply_ser #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n), .empty(empty), .head_id(head[EW-1]),
    .head_byte(head[DW-1:0]), .pop(pop), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/gcc_chk.sv
module gcc_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_valid,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [DW-1:0]   tx_data,
  input logic            start_seq,
  input logic            arm_toggle,
  input logic            reset_target,
  input logic [2*DW-1:0] delay_cyc,
  input logic [DW-1:0]   width_cyc,
  input logic [DW-1:0]   count_cyc,
  input logic [2*DW-1:0] spacing_cyc,
  input logic [2*DW-1:0] reset_len,
  input logic [1:0]      reset_mode
);
  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  act_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seq || arm_toggle || reset_target) |-> $past(rx_valid));

  // R6
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_seq, arm_toggle, reset_target}));

  // R5
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable({delay_cyc, width_cyc, count_cyc,
                                  spacing_cyc, reset_len, reset_mode}));

  // R7
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode != 2'd3);
endmodule

bind glitch_cmd_ctrl gcc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .start_seq(start_seq),
  .arm_toggle(arm_toggle), .reset_target(reset_target),
  .delay_cyc(delay_cyc), .width_cyc(width_cyc), .count_cyc(count_cyc),
  .spacing_cyc(spacing_cyc), .reset_len(reset_len), .reset_mode(reset_mode)
);

// File: tb/sim_glitch_cmd_ctrl.sv
module sim_glitch_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic [15:0] delay_cyc, spacing_cyc, reset_len;
  logic [7:0]  width_cyc, count_cyc;
  logic [1:0]  reset_mode;
  logic        start_seq, arm_toggle, reset_target;

  always #(CLK_PERIOD/2) clk = ~clk;

  glitch_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .delay_cyc(delay_cyc), .width_cyc(width_cyc), .count_cyc(count_cyc),
    .spacing_cyc(spacing_cyc), .reset_len(reset_len), .reset_mode(reset_mode),
    .start_seq(start_seq), .arm_toggle(arm_toggle), .reset_target(reset_target)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_start = 0, n_arm = 0, n_trst = 0, n_tx = 0;
  bit hold_low = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  int          m_left = 0;
  logic [7:0]  m_op = '0, m_hi = '0;
  logic [15:0] m_delay = 16'h0, m_space = 16'h0, m_rlen = 16'h0;
  logic [7:0]  m_width = 8'h1, m_count = 8'h1;
  logic [1:0]  m_mode = 2'd0;
  bit          m_start = 0, m_arm = 0, m_trst = 0;
  logic [7:0]  exp_q[$];

  function automatic void chk(input bit ok, input string req,
                              input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0; m_delay = 0; m_space = 0; m_rlen = 0;
      m_width = 1; m_count = 1; m_mode = 0;
      m_start = 0; m_arm = 0; m_trst = 0;
    end else begin
      m_start = 0; m_arm = 0; m_trst = 0;
      if (start_seq) n_start++;
      if (arm_toggle) n_arm++;
      if (reset_target) n_trst++;
      if (tx_valid && tx_ready) n_tx++;
      if (rx_valid) begin
        if (m_left == 2) begin
          m_hi = rx_data; m_left = 1;
          if (m_op == 8'h77 || m_op == 8'h6E) m_left = 0;
          if (m_op == 8'h77) m_width = rx_data;
          if (m_op == 8'h6E) m_count = rx_data;
        end else if (m_left == 1) begin
          m_left = 0;
          if (m_op == 8'h64) m_delay = {m_hi, rx_data};
          if (m_op == 8'h73) m_space = {m_hi, rx_data};
          if (m_op == 8'h72) m_rlen  = {m_hi, rx_data};
        end else begin
          m_op = rx_data;
          case (rx_data)
            8'h64, 8'h73, 8'h72, 8'h77, 8'h6E: m_left = 2;
            8'h74: m_start = 1;
            8'h61: m_arm = 1;
            8'h70: m_trst = 1;
            8'h75: m_mode = 2'd0;
            8'h69: m_mode = 2'd1;
            8'h79: m_mode = 2'd2;
            8'h68: begin
              exp_q.push_back(8'h46); exp_q.push_back(8'h4C);
              exp_q.push_back(8'h54); exp_q.push_back(8'h30);
              exp_q.push_back(8'h31);
            end
            default: exp_q.push_back(rx_data);
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tx_ready = !hold_low && ((cyc % 3) != 0);
      if (rst_n) begin
        chk(delay_cyc == m_delay, "R2 delay", delay_cyc, m_delay);
        chk(spacing_cyc == m_space, "R2 spacing", spacing_cyc, m_space);
        chk(reset_len == m_rlen, "R2 reset_len", reset_len, m_rlen);
        chk(width_cyc == m_width, "R3 width", width_cyc, m_width);
        chk(count_cyc == m_count, "R3 count", count_cyc, m_count);
        chk(reset_mode == m_mode, "R7 mode", reset_mode, m_mode);
        chk(start_seq == m_start, "R6 start", start_seq, m_start);
        chk(arm_toggle == m_arm, "R6 arm", arm_toggle, m_arm);
        chk(reset_target == m_trst, "R6 reset_target", reset_target, m_trst);
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0)
            chk(1'b0, "R9 R10 unexpected tx byte", tx_data, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(tx_data == e, "R9 R10 tx byte", tx_data, e);
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc >= WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(delay_cyc == 16'h0 && spacing_cyc == 16'h0 && reset_len == 16'h0,
        "R1 16-bit regs", {delay_cyc, spacing_cyc[7:0], reset_len[7:0]}, 0);
    chk(width_cyc == 8'h1 && count_cyc == 8'h1, "R1 8-bit regs",
        {width_cyc, count_cyc}, 16'h0101);
    chk(reset_mode == 2'd0, "R1 mode", reset_mode, 0);
    chk(!tx_valid && !start_seq && !arm_toggle && !reset_target,
        "R1 outputs idle", {tx_valid, start_seq, arm_toggle, reset_target}, 0);

    send(8'h64); send(8'h12);
    chk(delay_cyc == 16'h0, "R5 delay held mid-argument", delay_cyc, 0);
    send(8'h34);
    chk(delay_cyc == 16'h1234, "R2 delay high byte first", delay_cyc, 16'h1234);
    send(8'h77); send(8'h74);
    chk(width_cyc == 8'h74, "R4 argument equal to start opcode", width_cyc, 8'h74);
    send(8'h6E); send(8'h61);
    chk(count_cyc == 8'h61, "R3 count", count_cyc, 8'h61);
    send(8'h73); send(8'h70); send(8'h68);
    chk(spacing_cyc == 16'h7068, "R4 spacing args look like opcodes",
        spacing_cyc, 16'h7068);
    send(8'h72); send(8'hAB); send(8'hCD);
    chk(reset_len == 16'hABCD, "R2 reset_len", reset_len, 16'hABCD);
    chk(n_start + n_arm + n_trst == 0, "R8 no action from configuration",
        n_start + n_arm + n_trst, 0);
    chk(n_tx == 0 && !tx_valid, "R8 no reply from configuration", n_tx, 0);

    send(8'h74);
    chk(n_start == 1, "R6 start pulse count", n_start, 1);
    send(8'h61);
    chk(n_arm == 1, "R6 arm pulse count", n_arm, 1);
    send(8'h70);
    chk(n_trst == 1, "R6 reset_target pulse count", n_trst, 1);

    send(8'h69);
    chk(reset_mode == 2'd1, "R7 mode arm", reset_mode, 1);
    send(8'h79);
    chk(reset_mode == 2'd2, "R7 mode none", reset_mode, 2);
    send(8'h75);
    chk(reset_mode == 2'd0, "R7 mode pulse", reset_mode, 0);

    send(8'h78);
    send(8'h68);
    send(8'h00);
    repeat (30) @(negedge clk);

    hold_low = 1'b1;
    send(8'h68);
    chk(tx_valid && tx_data == 8'h46, "R11 stalled first id byte", tx_data, 8'h46);
    repeat (8) @(negedge clk);
    chk(tx_valid && tx_data == 8'h46, "R11 byte held during stall", tx_data, 8'h46);
    hold_low = 1'b0;

    for (int i = 0; i < 200 && (exp_q.size() != 0 || tx_valid); i++)
      @(negedge clk);
    chk(exp_q.size() == 0, "R9 all replies delivered", exp_q.size(), 0);
    chk(n_tx == 12, "R10 total reply bytes", n_tx, 12);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule